// File: doc/BRIEF.md
# Low-Power Mode Control Sequencer

This block decides the operating state of a processor core. It covers normal execution, handing the bus to a secondary master, three power-down states, a slow-clock state and the recovery paths out of each of them. On a sleep strobe it reads three configuration bits: standby select, low-speed enable and watchdog clock select. From these it picks the power-down state. An interrupt wakes the core. Leaving software standby first waits through a programmable settling interval.

An active-low standby pin overrides every other transition and forces the deepest standby. In that state the peripherals are held in reset. When the pin is released, the core comes back through a reset sequence of fixed length. It does not resume where it stopped. Two secondary masters can request the bus. The sequencer grants the bus one-hot, and it can do so while the core sleeps without waking it. A medium-speed select and per-module stop enables pass through a register to the clock and peripheral logic. Neither of them ever halts the CPU.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, state_o is 0 (run), cpu_halt_o is 0, clk_en_o is 1, and periph_rst_o, io_hold_o and bus_gnt_o are all 0.
- R2: In run state, a sleep strobe with standby select 0 and low-speed 0 gives state_o 2 (sleep) on the next cycle, with cpu_halt_o 1 and clk_en_o 1.
- R3: In run state, a sleep strobe with standby select 1, low-speed 0 and watchdog clock select 0 gives state_o 3 (software standby) on the next cycle, with cpu_halt_o 1, clk_en_o 0 and io_hold_o 1.
- R4: In run state, a sleep strobe with any other bit combination gives state_o 7 (subactive) on the next cycle, with cpu_halt_o 0. This applies when the subactive mode is enabled.
- R5: In sleep, irq_i or ext_irq_i returns state_o to 0 on the next cycle.
- R6: In software standby, irq_i alone has no effect. ext_irq_i moves the core to state_o 4 (settling) for settle_i+1 cycles, with clk_en_o 0, and then to state_o 0.
- R7: When stby_ni is low at a clock edge, state_o is 5 (hardware standby) after the third rising edge, whatever the prior state. In that state clk_en_o is 0 and periph_rst_o is 1.
- R8: When stby_ni returns high, state_o is 6 (standby reset) after the third rising edge. It stays 6 for RST_CYC cycles with periph_rst_o 1 and clk_en_o 1, then becomes 0.
- R9: In run state, any bus request gives state_o 1 (bus released) and cpu_halt_o 1 on the next cycle. The grant is one-hot, and master 0 wins a tie. A master that holds the grant keeps it while its request stays high.
- R10: Once all requests are low, the grant is 0 and state_o is 0 one cycle later.
- R11: A bus request during sleep is granted while state_o stays 2. When the request is removed, the grant clears.
- R12: mod_stop_o and med_clk_o follow mod_stop_i and med_spd_i one cycle later, and they never set cpu_halt_o.
- R13: In subactive, irq_i returns state_o to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | One-cycle sleep instruction strobe |
| ssby_i | input | 1 | Standby select bit |
| lson_i | input | 1 | Low-speed enable bit |
| wdt_sel_i | input | 1 | Watchdog clock select bit |
| stby_ni | input | 1 | Asynchronous active-low hardware standby pin |
| bus_req_i | input | NMST | Secondary master bus requests |
| irq_i | input | 1 | Any enabled interrupt |
| ext_irq_i | input | 1 | External interrupt |
| settle_i | input | SETTLE_W | Oscillator settling length |
| med_spd_i | input | 1 | Medium-speed clock request |
| mod_stop_i | input | NMOD | Per-module stop requests |
| state_o | output | 3 | Current state code |
| cpu_halt_o | output | 1 | CPU halted |
| clk_en_o | output | 1 | System clock gate enable |
| periph_rst_o | output | 1 | Peripheral reset |
| io_hold_o | output | 1 | Freeze I/O port outputs |
| bus_gnt_o | output | NMST | One-hot bus grant |
| med_clk_o | output | 1 | Medium-speed clock select |
| mod_stop_o | output | NMOD | Per-module stop enables |

## Verification
Every transition driven by a strobe, an interrupt or a bus request shows on the outputs one rising edge after the input is sampled. The stimulus is applied on falling edges and the outputs are sampled on the next falling edge. The standby pin goes through a two-flop synchronizer, so its effect is due after the third rising edge, and the bench checks both the second edge, where nothing has changed yet, and the third. The settling and standby-reset intervals are measured by counting falling-edge samples spent in the state, and the counts are compared with settle_i+1 and RST_CYC.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_BUSREL = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_SWSTBY = 3'd3,
    ST_SETTLE = 3'd4,
    ST_HWSTBY = 3'd5,
    ST_HWRST  = 3'd6,
    ST_SUBACT = 3'd7
  } pm_state_e;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pms_cnt.sv
module pms_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (ld_i)            cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !ld_i) |=> zero_o); // R6
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int unsigned NMST      = 2,
  parameter int unsigned SUBACT_EN = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_i,
  input  logic            ssby_i,
  input  logic            lson_i,
  input  logic            wdt_sel_i,
  input  logic            hw_run_i,
  input  logic [NMST-1:0] bus_req_i,
  input  logic            irq_i,
  input  logic            ext_irq_i,
  input  logic            cnt_zero_i,
  output pm_state_e       state_o,
  output logic            cnt_ld_o,
  output logic            cnt_rst_sel_o,
  output logic [NMST-1:0] bus_gnt_o
);
  localparam bit HAS_SUBACT = (SUBACT_EN != 0);

  pm_state_e       st_q, st_d;
  logic [NMST-1:0] gnt_q, gnt_d, pick;
  logic            any_req, any_irq;

  assign any_req = |bus_req_i;
  assign any_irq = irq_i | ext_irq_i;

  always_comb begin
    st_d          = st_q;
    cnt_ld_o      = 1'b0;
    cnt_rst_sel_o = 1'b0;
    if (!hw_run_i) begin
      st_d = ST_HWSTBY;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (any_req) st_d = ST_BUSREL;
          else if (sleep_i) begin
            if (!ssby_i && !lson_i)                    st_d = ST_SLEEP;
            else if (ssby_i && !lson_i && !wdt_sel_i)  st_d = ST_SWSTBY;
            else if (HAS_SUBACT)                       st_d = ST_SUBACT;
          end
        end
        ST_BUSREL: if (!any_req) st_d = ST_RUN;
        ST_SLEEP:  if (any_irq) st_d = any_req ? ST_BUSREL : ST_RUN;
        ST_SWSTBY: if (ext_irq_i) begin
          st_d     = ST_SETTLE;
          cnt_ld_o = 1'b1;
        end
        ST_SETTLE: if (cnt_zero_i) st_d = ST_RUN;
        ST_HWSTBY: begin
          st_d          = ST_HWRST;
          cnt_ld_o      = 1'b1;
          cnt_rst_sel_o = 1'b1;
        end
        ST_HWRST:  if (cnt_zero_i) st_d = ST_RUN;
        ST_SUBACT: if (any_irq) st_d = ST_RUN;
        default:   st_d = ST_RUN;
      endcase
    end
  end

  // lowest index wins a new arbitration
  always_comb begin
    pick = '0;
    for (int i = NMST - 1; i >= 0; i--) begin
      if (bus_req_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_d = '0;
    if (st_d == ST_BUSREL || st_d == ST_SLEEP)
      gnt_d = (|(gnt_q & bus_req_i)) ? gnt_q : pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      gnt_q <= '0;
    end else begin
      st_q  <= st_d;
      gnt_q <= gnt_d;
    end
  end

  assign state_o   = st_q;
  assign bus_gnt_o = gnt_q;

  AST_HW_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_run_i |=> st_q == ST_HWSTBY); // R7
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_gnt_o)); // R9
  AST_GNT_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_gnt_o) |-> (st_q == ST_BUSREL || st_q == ST_SLEEP)); // R11
  AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSREL && !any_req && hw_run_i) |=> (st_q == ST_RUN && bus_gnt_o == '0)); // R10
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && any_irq && !any_req && hw_run_i) |=> st_q == ST_RUN); // R5
  AST_SWSTBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SWSTBY && !ext_irq_i && hw_run_i) |=> st_q == ST_SWSTBY); // R6
endmodule

// File: rtl/pms_out.sv
module pms_out
  import pms_pkg::*;
#(
  parameter int unsigned NMOD = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pm_state_e       state_i,
  input  logic            med_spd_i,
  input  logic [NMOD-1:0] mod_stop_i,
  output logic            cpu_halt_o,
  output logic            clk_en_o,
  output logic            periph_rst_o,
  output logic            io_hold_o,
  output logic            med_clk_o,
  output logic [NMOD-1:0] mod_stop_o
);
  assign cpu_halt_o   = !(state_i == ST_RUN || state_i == ST_SUBACT);
  assign clk_en_o     = !(state_i == ST_SWSTBY || state_i == ST_SETTLE || state_i == ST_HWSTBY);
  assign periph_rst_o = (state_i == ST_HWSTBY || state_i == ST_HWRST);
  assign io_hold_o    = (state_i == ST_SWSTBY || state_i == ST_SETTLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) med_clk_o <= 1'b0;
    else         med_clk_o <= med_spd_i;
  end

  for (genvar m = 0; m < NMOD; m++) begin : g_mstp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mod_stop_o[m] <= 1'b0;
      else         mod_stop_o[m] <= mod_stop_i[m];
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int unsigned NMST      = 2,
  parameter int unsigned NMOD      = 4,
  parameter int unsigned SETTLE_W  = 4,
  parameter int unsigned RST_CYC   = 5,
  parameter int unsigned SUBACT_EN = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_i,
  input  logic                ssby_i,
  input  logic                lson_i,
  input  logic                wdt_sel_i,
  input  logic                stby_ni,
  input  logic [NMST-1:0]     bus_req_i,
  input  logic                irq_i,
  input  logic                ext_irq_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                med_spd_i,
  input  logic [NMOD-1:0]     mod_stop_i,
  output logic [2:0]          state_o,
  output logic                cpu_halt_o,
  output logic                clk_en_o,
  output logic                periph_rst_o,
  output logic                io_hold_o,
  output logic [NMST-1:0]     bus_gnt_o,
  output logic                med_clk_o,
  output logic [NMOD-1:0]     mod_stop_o
);
  localparam int unsigned RW    = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
  localparam int unsigned CNT_W = (SETTLE_W > RW) ? SETTLE_W : RW;
  localparam logic [CNT_W-1:0] RST_LEN = CNT_W'(RST_CYC - 1);

  logic             hw_run, cnt_ld, cnt_rst_sel, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  pm_state_e        st;

  pms_sync #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stby_ni), .q_o(hw_run)
  );

  assign cnt_val = cnt_rst_sel ? RST_LEN : CNT_W'(settle_i);

  pms_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cnt_ld), .val_i(cnt_val), .zero_o(cnt_zero)
  );

  pms_fsm #(.NMST(NMST), .SUBACT_EN(SUBACT_EN)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .ssby_i(ssby_i),
    .lson_i(lson_i), .wdt_sel_i(wdt_sel_i), .hw_run_i(hw_run),
    .bus_req_i(bus_req_i), .irq_i(irq_i), .ext_irq_i(ext_irq_i),
    .cnt_zero_i(cnt_zero), .state_o(st), .cnt_ld_o(cnt_ld),
    .cnt_rst_sel_o(cnt_rst_sel), .bus_gnt_o(bus_gnt_o)
  );

  pms_out #(.NMOD(NMOD)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(st), .med_spd_i(med_spd_i),
    .mod_stop_i(mod_stop_i), .cpu_halt_o(cpu_halt_o), .clk_en_o(clk_en_o),
    .periph_rst_o(periph_rst_o), .io_hold_o(io_hold_o), .med_clk_o(med_clk_o),
    .mod_stop_o(mod_stop_o)
  );

  assign state_o = st;

  AST_STBY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hold_o |-> (!clk_en_o && cpu_halt_o)); // R3
  AST_PRST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_rst_o |-> cpu_halt_o); // R8
  AST_RUN_CLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o |-> (clk_en_o && !periph_rst_o)); // R12
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int CLK_P   = 10;
  localparam int NMST    = 2;
  localparam int NMOD    = 4;
  localparam int SW      = 4;
  localparam int RST_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 0, ssby = 0, lson = 0, wdt = 0, stby_n = 1, irq = 0, ext = 0, med = 0;
  logic [NMST-1:0] req = '0;
  logic [SW-1:0]   settle = '0;
  logic [NMOD-1:0] mstop = '0;
  logic [2:0]      state;
  logic            halt, clk_en, prst, hold, med_o;
  logic [NMST-1:0] gnt;
  logic [NMOD-1:0] mstop_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_seq #(.NMST(NMST), .NMOD(NMOD), .SETTLE_W(SW), .RST_CYC(RST_CYC), .SUBACT_EN(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .ssby_i(ssby), .lson_i(lson),
    .wdt_sel_i(wdt), .stby_ni(stby_n), .bus_req_i(req), .irq_i(irq), .ext_irq_i(ext),
    .settle_i(settle), .med_spd_i(med), .mod_stop_i(mstop), .state_o(state),
    .cpu_halt_o(halt), .clk_en_o(clk_en), .periph_rst_o(prst), .io_hold_o(hold),
    .bus_gnt_o(gnt), .med_clk_o(med_o), .mod_stop_o(mstop_o)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic l, input logic w);
    ssby = s; lson = l; wdt = w; sleep = 1; tick(); sleep = 0;
  endtask

  task automatic wake_irq();
    irq = 1; tick(); irq = 0;
  endtask

  // wake from software standby; returns samples spent settling
  task automatic wake_sw(input int s, output int n);
    settle = SW'(s); ext = 1; tick(); ext = 0;
    n = 0;
    while (state == 3'd4 && n < 64) begin
      if (clk_en !== 1'b0) chk("R6 clk gated in settle", clk_en, 0);
      tick(); n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, exp_st;
    repeat (2) @(negedge clk);
    rst_n = 1; tick();
    // R1
    chk("R1 state", state, 0); chk("R1 halt", halt, 0); chk("R1 clk_en", clk_en, 1);
    chk("R1 prst", prst, 0); chk("R1 hold", hold, 0); chk("R1 gnt", gnt, 0);

    // R2 R3 R4 R5 R13: sweep all strobe bit combinations
    for (int c = 0; c < 8; c++) begin
      logic s, l, w;
      s = c[2]; l = c[1]; w = c[0];
      if (!s && !l) exp_st = 2; else if (s && !l && !w) exp_st = 3; else exp_st = 7;
      strobe(s, l, w);
      chk(exp_st == 2 ? "R2 state" : exp_st == 3 ? "R3 state" : "R4 state", state, exp_st);
      if (exp_st == 2) begin
        chk("R2 halt", halt, 1); chk("R2 clk_en", clk_en, 1);
        wake_irq(); chk("R5 wake", state, 0);
      end else if (exp_st == 3) begin
        chk("R3 halt", halt, 1); chk("R3 clk_en", clk_en, 0); chk("R3 hold", hold, 1);
        wake_irq(); chk("R6 irq ignored", state, 3);
        wake_sw(2, n); chk("R6 settle len", n, 3); chk("R6 back", state, 0);
      end else begin
        chk("R4 halt", halt, 0);
        wake_irq(); chk("R13 wake", state, 0);
      end
    end

    // R5 external interrupt also wakes sleep
    strobe(0, 0, 0); ext = 1; tick(); ext = 0; chk("R5 ext wake", state, 0);

    // R6 settle sweep
    for (int s = 0; s < (1 << SW); s++) begin
      strobe(1, 0, 0);
      wake_sw(s, n);
      chk("R6 settle len", n, s + 1);
      chk("R6 state", state, 0);
    end

    // R7 R8 from several starting states
    for (int k = 0; k < 4; k++) begin
      if (k == 1) strobe(0, 0, 0);
      if (k == 2) strobe(1, 0, 0);
      if (k == 3) begin req = 2'b01; tick(); end
      stby_n = 0; tick(); tick();
      chk("R7 not yet", state == 3'd5, 0);
      req = '0; tick();
      chk("R7 hw standby", state, 5); chk("R7 clk_en", clk_en, 0); chk("R7 prst", prst, 1);
      tick(); chk("R7 held", state, 5);
      stby_n = 1; tick(); tick();
      chk("R8 not yet", state, 5);
      tick(); n = 0;
      while (state == 3'd6 && n < 64) begin
        if (prst !== 1'b1 || clk_en !== 1'b1) chk("R8 rst outputs", {prst, clk_en}, 3);
        tick(); n++;
      end
      chk("R8 reset len", n, RST_CYC);
      chk("R8 back", state, 0);
    end

    // R9 R10 request patterns
    for (int r = 1; r < 4; r++) begin
      req = NMST'(r); tick();
      chk("R9 state", state, 1); chk("R9 halt", halt, 1);
      chk("R9 gnt", gnt, r[0] ? 1 : 2);
      req = '0; tick();
      chk("R10 state", state, 0); chk("R10 gnt", gnt, 0);
    end
    req = 2'b10; tick(); chk("R9 gnt m1", gnt, 2);
    req = 2'b11; tick(); chk("R9 owner kept", gnt, 2);
    req = 2'b01; tick(); chk("R9 handover", gnt, 1);
    req = 2'b00; tick(); chk("R10 release", gnt, 0); chk("R10 state", state, 0);

    // R11 grant during sleep
    strobe(0, 0, 0);
    req = 2'b10; tick();
    chk("R11 state", state, 2); chk("R11 gnt", gnt, 2); chk("R11 halt", halt, 1);
    req = 2'b00; tick();
    chk("R11 gnt clear", gnt, 0); chk("R11 still asleep", state, 2);
    wake_irq(); chk("R11 wake", state, 0);

    // R12 module stop / medium speed sweep
    for (int m = 0; m < (1 << NMOD); m++) begin
      mstop = NMOD'(m); med = m[0]; tick();
      chk("R12 mstop", mstop_o, m); chk("R12 med", med_o, m & 1); chk("R12 halt", halt, 0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule